// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block is a small stack-machine datapath. It accepts one instruction at a time over a valid/ready handshake. Each instruction carries a two-bit opcode and, for the memory instructions, a data-memory address. The block keeps an internal operand stack in a register array with a stack-pointer register. It reaches data through a single-port synchronous memory whose read data arrives one cycle after the request.

Arithmetic instructions carry no operand fields at all. An add or a subtract consumes the two topmost stack entries. The result replaces the deeper of the two, and that entry becomes the new top. Moving a value from memory onto the stack reads the addressed word and makes it the new top. Moving a value off the stack writes the top word to the addressed location and removes it. Illegal stack use is reported on two flags, one for a full stack and one for an empty stack. Each flag is a single-cycle pulse in the cycle after the offending instruction is accepted, and that instruction has no other effect.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, `instr_ready_o` is 1, both flags are 0 and the stack is empty.
- R2: A load instruction (opcode 0) issues `mem_req_o`=1, `mem_we_o`=0, `mem_addr_o`=address in its acceptance cycle. `instr_ready_o` is 0 in the following cycle. The word returned in that cycle becomes the new top of stack.
- R3: A store instruction (opcode 1) on a non-empty stack issues `mem_req_o`=1, `mem_we_o`=1, `mem_addr_o`=address, `mem_wdata_o`=top word in its acceptance cycle. It removes that entry, so values come off in the reverse of their load order.
- R4: An add (opcode 2) with at least two entries makes no memory request. It completes in one cycle and leaves the sum of the two topmost entries as the new top, with one entry fewer.
- R5: A subtract (opcode 3) leaves the deeper entry minus the top entry, modulo 2^32.
- R6: The sequence load A, load B, add, store C writes A+B to location C.
- R7: A load onto a full stack (8 entries by default) makes no memory request. It pulses `overflow_o` for one cycle and leaves the stack contents and depth unchanged.
- R8: An add or subtract with fewer than two entries pulses `underflow_o` for one cycle. It makes no memory request and leaves the stack unchanged.
- R9: A store on an empty stack pulses `underflow_o` for one cycle and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction offered |
| instr_ready_o | output | 1 | Instruction can be accepted this cycle |
| instr_op_i | input | 2 | Opcode: 0 load, 1 store, 2 add, 3 subtract |
| instr_addr_i | input | 8 | Memory address for load and store |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 8 | Memory address |
| mem_wdata_o | output | 32 | Write data (top of stack) |
| mem_rdata_i | input | 32 | Read data, valid one cycle after a read request |
| overflow_o | output | 1 | Pulse: load onto a full stack was discarded |
| underflow_o | output | 1 | Pulse: too few entries for the accepted instruction |

## Verification
A wrong stack pointer shows up at the latest on the next store. That store writes a stale or wrong word, or raises or omits an underflow pulse. Draining a filled stack, and then issuing one further store, exposes a depth that is off by one. A wrong operand order or a wrong write slot shows in the first store after an arithmetic instruction. A push that is not actually discarded on a full stack reveals itself at the first store after the overflow. A fill cycle that is mishandled shows at once as `instr_ready_o` staying high in the cycle after a load.

// File: rtl/stack_exec_pkg.sv
package stack_exec_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_ADD  = 2'd2,
    OP_SUB  = 2'd3
  } stk_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } ctrl_state_e;

  typedef enum logic {
    SRC_MEM = 1'b0,
    SRC_ALU = 1'b1
  } wr_src_e;
endpackage

// File: rtl/stack_regfile.sv
module stack_regfile #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IW-1:0]    widx_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [IW-1:0]    top_idx_i,
  input  logic [IW-1:0]    sec_idx_i,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] sec_o
);
  logic [WIDTH-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))    ent_q[g] <= wdata_i;
    end
  end

  assign top_o = ent_q[top_idx_i];
  assign sec_o = ent_q[sec_idx_i];
endmodule

// File: rtl/stack_alu.sv
module stack_alu #(
  parameter int WIDTH = 32
) (
  input  logic             sub_i,
  input  logic [WIDTH-1:0] sec_i,
  input  logic [WIDTH-1:0] top_i,
  output logic [WIDTH-1:0] res_o
);
  // deeper entry is the left operand
  always_comb begin
    if (sub_i) res_o = sec_i - top_i;
    else       res_o = sec_i + top_i;
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_exec_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  stk_op_e       op_i,
  output logic          ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          stk_we_o,
  output logic [IW-1:0] stk_widx_o,
  output wr_src_e       stk_src_o,
  output logic [IW-1:0] top_idx_o,
  output logic [IW-1:0] sec_idx_o,
  output logic          ovf_o,
  output logic          unf_o
);
  ctrl_state_e    state_q, state_d;
  logic [CW-1:0]  sp_q, sp_d;
  logic           ovf_q, ovf_d, unf_q, unf_d;
  logic [CW-1:0]  sp_m1, sp_m2;
  logic           full, has1, has2, accept;

  assign sp_m1  = sp_q - CW'(1);
  assign sp_m2  = sp_q - CW'(2);
  assign full   = (sp_q == CW'(DEPTH));
  assign has1   = (sp_q != '0);
  assign has2   = (sp_q >= CW'(2));
  assign ready_o = (state_q == ST_IDLE);
  assign accept = valid_i && ready_o;

  assign top_idx_o = sp_m1[IW-1:0];
  assign sec_idx_o = sp_m2[IW-1:0];

  always_comb begin
    state_d    = state_q;
    sp_d       = sp_q;
    ovf_d      = 1'b0;
    unf_d      = 1'b0;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    stk_we_o   = 1'b0;
    stk_widx_o = sp_q[IW-1:0];
    stk_src_o  = SRC_MEM;
    if (state_q == ST_FILL) begin
      // read data lands in the slot above the current top
      stk_we_o = 1'b1;
      sp_d     = sp_q + CW'(1);
      state_d  = ST_IDLE;
    end else if (accept) begin
      unique case (op_i)
        OP_PUSH: begin
          if (full) ovf_d = 1'b1;
          else begin
            mem_req_o = 1'b1;
            state_d   = ST_FILL;
          end
        end
        OP_POP: begin
          if (!has1) unf_d = 1'b1;
          else begin
            mem_req_o = 1'b1;
            mem_we_o  = 1'b1;
            sp_d      = sp_m1;
          end
        end
        default: begin
          if (!has2) unf_d = 1'b1;
          else begin
            stk_we_o   = 1'b1;
            stk_widx_o = sp_m2[IW-1:0];
            stk_src_o  = SRC_ALU;
            sp_d       = sp_m1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sp_q    <= sp_d;
      ovf_q   <= ovf_d;
      unf_q   <= unf_d;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  // R1
  sp_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= CW'(DEPTH));

  // R2
  push_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_i == OP_PUSH && !full) |=> (!ready_o && stk_we_o));

  // R4
  arith_shrink_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (op_i == OP_ADD || op_i == OP_SUB) && has2)
      |=> (sp_q == $past(sp_q) - CW'(1)));

  // R7
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (sp_q == CW'(DEPTH) && $stable(sp_q)));

  // R8
  unf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |-> ($stable(sp_q) && sp_q < CW'(2)));

  // R9
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_q, unf_q}));
endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit
  import stack_exec_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  output logic             instr_ready_o,
  input  logic [1:0]       instr_op_i,
  input  logic [AW-1:0]    instr_addr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [WIDTH-1:0] mem_wdata_o,
  input  logic [WIDTH-1:0] mem_rdata_i,
  output logic             overflow_o,
  output logic             underflow_o
);
  stk_op_e          op;
  logic             stk_we;
  logic [IW-1:0]    stk_widx, top_idx, sec_idx;
  wr_src_e          stk_src;
  logic [WIDTH-1:0] top_w, sec_w, alu_res, stk_wdata;

  assign op = stk_op_e'(instr_op_i);

  stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (instr_valid_i),
    .op_i       (op),
    .ready_o    (instr_ready_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .stk_we_o   (stk_we),
    .stk_widx_o (stk_widx),
    .stk_src_o  (stk_src),
    .top_idx_o  (top_idx),
    .sec_idx_o  (sec_idx),
    .ovf_o      (overflow_o),
    .unf_o      (underflow_o)
  );

  stack_alu #(.WIDTH(WIDTH)) u_alu (
    .sub_i (op == OP_SUB),
    .sec_i (sec_w),
    .top_i (top_w),
    .res_o (alu_res)
  );

  assign stk_wdata = (stk_src == SRC_ALU) ? alu_res : mem_rdata_i;

  stack_regfile #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (stk_we),
    .widx_i    (stk_widx),
    .wdata_i   (stk_wdata),
    .top_idx_i (top_idx),
    .sec_idx_i (sec_idx),
    .top_o     (top_w),
    .sec_o     (sec_w)
  );

  assign mem_addr_o  = instr_addr_i;
  assign mem_wdata_o = top_w;

  // R3
  we_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && instr_ready_o));

  // R2
  no_req_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_ready_o |-> !mem_req_o);
endmodule

// File: tb/stack_exec_unit_test.sv
module stack_exec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic        instr_ready_o;
  logic [1:0]  instr_op_i = 2'd0;
  logic [7:0]  instr_addr_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [7:0]  mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic        overflow_o, underflow_o;

  logic [31:0] mem [256];
  int checks = 0;
  int errors = 0;

  logic        s_req, s_we, s_ready, s_ovf, s_unf;
  logic [7:0]  s_addr;
  logic [31:0] s_wdata;

  always #2 clk = ~clk;

  stack_exec_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .instr_valid_i(instr_valid_i), .instr_ready_o(instr_ready_o),
    .instr_op_i(instr_op_i), .instr_addr_i(instr_addr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata_i <= mem[mem_addr_o];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] addr);
    @(negedge clk);
    while (!instr_ready_o) @(negedge clk);
    instr_valid_i = 1'b1;
    instr_op_i    = op;
    instr_addr_i  = addr;
    #1;
    s_req = mem_req_o; s_we = mem_we_o; s_addr = mem_addr_o; s_wdata = mem_wdata_o;
    @(negedge clk);
    instr_valid_i = 1'b0;
    s_ready = instr_ready_o; s_ovf = overflow_o; s_unf = underflow_o;
  endtask

  task automatic t_reset;
    chk("R1 ready", {31'd0, instr_ready_o}, 32'd1);
    chk("R1 overflow", {31'd0, overflow_o}, 32'd0);
    chk("R1 underflow", {31'd0, underflow_o}, 32'd0);
  endtask

  task automatic t_pop_empty;
    mem[50] = 32'hAAAA_0050;
    send(2'd1, 8'd50);
    chk("R9 no req", {31'd0, s_req}, 32'd0);
    chk("R9 underflow", {31'd0, s_unf}, 32'd1);
    chk("R9 no overflow", {31'd0, s_ovf}, 32'd0);
    @(negedge clk);
    chk("R9 pulse ends", {31'd0, underflow_o}, 32'd0);
    chk("R9 mem intact", mem[50], 32'hAAAA_0050);
  endtask

  task automatic t_add;
    mem[10] = 32'h1234_5678;
    mem[11] = 32'h0FED_CBA9;
    send(2'd0, 8'd10);
    chk("R2 req", {31'd0, s_req}, 32'd1);
    chk("R2 read", {31'd0, s_we}, 32'd0);
    chk("R2 addr", {24'd0, s_addr}, 32'd10);
    chk("R2 busy", {31'd0, s_ready}, 32'd0);
    send(2'd0, 8'd11);
    send(2'd2, 8'd0);
    chk("R4 no req", {31'd0, s_req}, 32'd0);
    chk("R4 ready", {31'd0, s_ready}, 32'd1);
    send(2'd1, 8'd20);
    chk("R3 write", {31'd0, s_we & s_req}, 32'd1);
    chk("R3 addr", {24'd0, s_addr}, 32'd20);
    chk("R4 sum on top", s_wdata, 32'h1234_5678 + 32'h0FED_CBA9);
    chk("R6 mem C", mem[20], 32'h1234_5678 + 32'h0FED_CBA9);
  endtask

  task automatic t_sub;
    mem[12] = 32'd100;
    mem[13] = 32'd30;
    send(2'd0, 8'd12);
    send(2'd0, 8'd13);
    send(2'd3, 8'd0);
    send(2'd1, 8'd21);
    chk("R5 second-top", mem[21], 32'd70);
    send(2'd0, 8'd13);
    send(2'd0, 8'd12);
    send(2'd3, 8'd0);
    send(2'd1, 8'd22);
    chk("R5 wrap", mem[22], 32'hFFFF_FFBA);
  endtask

  task automatic t_lifo;
    mem[30] = 32'hC0DE_0030;
    mem[31] = 32'hC0DE_0031;
    mem[32] = 32'hC0DE_0032;
    send(2'd0, 8'd30);
    send(2'd0, 8'd31);
    send(2'd0, 8'd32);
    send(2'd1, 8'd40);
    send(2'd1, 8'd41);
    send(2'd1, 8'd42);
    chk("R3 lifo first", mem[40], 32'hC0DE_0032);
    chk("R3 lifo mid", mem[41], 32'hC0DE_0031);
    chk("R3 lifo last", mem[42], 32'hC0DE_0030);
  endtask

  task automatic t_underflow;
    mem[33] = 32'h5EED_0033;
    send(2'd2, 8'd0);
    chk("R8 add empty flag", {31'd0, s_unf}, 32'd1);
    @(negedge clk);
    chk("R8 pulse ends", {31'd0, underflow_o}, 32'd0);
    send(2'd0, 8'd33);
    send(2'd3, 8'd0);
    chk("R8 sub one flag", {31'd0, s_unf}, 32'd1);
    chk("R8 no req", {31'd0, s_req}, 32'd0);
    send(2'd1, 8'd43);
    chk("R8 stack unchanged", mem[43], 32'h5EED_0033);
    chk("R8 pop ok", {31'd0, s_unf}, 32'd0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 8; i++) mem[60+i] = 32'hF00D_0000 + 32'(i);
    mem[70] = 32'hDEAD_BEEF;
    for (int i = 0; i < 8; i++) send(2'd0, 8'(60 + i));
    chk("R7 fill no flag", {31'd0, overflow_o}, 32'd0);
    send(2'd0, 8'd70);
    chk("R7 no req", {31'd0, s_req}, 32'd0);
    chk("R7 overflow", {31'd0, s_ovf}, 32'd1);
    chk("R7 ready kept", {31'd0, s_ready}, 32'd1);
    @(negedge clk);
    chk("R7 pulse ends", {31'd0, overflow_o}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      send(2'd1, 8'(80 + i));
      chk("R7 drain order", mem[80+i], 32'hF00D_0007 - 32'(i));
    end
    send(2'd1, 8'd90);
    chk("R7 depth kept", {31'd0, s_unf}, 32'd1);
  endtask

  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0101_0101 * 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pop_empty();
    t_add();
    t_sub();
    t_lifo();
    t_underflow();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule